// File: doc/BRIEF.md
# On-Screen Display Write Command Parser

This block sits behind a two-wire serial slave front end. During a write transaction it turns the stream of received bytes into writes to a character display memory. Each byte is taken as a row address, a column address or display data, based on what the byte holds and where it falls in the stream. A byte with its top bit set is a row address. A byte with its top bit clear is a column address. Bit 6 of a column byte chooses between single-shot data and a streaming run.

Three addressing styles can be mixed in one transaction:
- **Triplet:** row, then column, then data.
- **Pair:** column, then data, which reuses the last row.
- **Streaming:** one row and one streaming column, followed by any number of data bytes. The position advances after each data byte.

Once streaming has started, nothing inside the transaction can leave it. Only a start or stop pulse ends streaming.

The parser has three states:
- **PS_ADDR:** an address is expected.
  - A valid row byte stays in PS_ADDR.
  - A valid column byte with bit 6 clear goes to PS_DATA.
  - A valid column byte with bit 6 set goes to PS_STREAM.
  - An out-of-range address byte stays in PS_ADDR.
- **PS_DATA:** a column is pending. Any byte is written as data, and the parser goes back to PS_ADDR.
- **PS_STREAM:** every byte is written as data, and the position steps forward.

A start or stop pulse moves any state to PS_ADDR.

Top module: `osd_cmd_parser`

## Requirements
- R1: In PS_ADDR, a byte with bit 7 = 1 loads the current row from bits 4..0 (valid values 0..NUM_ROWS-1). It causes no memory write.
- R2: In PS_ADDR, a byte with bit 7 = 0 and bit 6 = 0 loads the current column from bits 5..0 (valid values 0..NUM_COLS-1). The next byte, whatever its value, is written as data at the current row and column.
- R3: After a data write in PS_DATA, the next byte is decoded as an address again. A column byte followed by a data byte writes at the most recently loaded row.
- R4: A row byte, then a column byte, then a data byte writes the data at that row and column, at every position of the memory.
- R5: A column byte with bit 7 = 0 and bit 6 = 1 enters streaming. Each following byte is written at the current position, and the column then advances by one.
- R6: While streaming, bytes that look like row or column addresses (for example 0x85, 0x45, 0xC0) are written as data. Only a start or stop pulse leaves streaming.
- R7: During streaming, a write at column NUM_COLS-1 is followed by column 0 of the next row. After row NUM_ROWS-1 the position returns to row 0. Write addresses never leave the memory.
- R8: wr_en is high for exactly one cycle per accepted data byte. That cycle is the clock cycle after the cycle in which byte_valid presented the byte, and wr_row, wr_col and wr_data are valid with it.
- R9: An address byte whose row field is >= NUM_ROWS or whose column field is >= NUM_COLS is dropped. Dropping it changes neither state nor position, and it sets proto_err. proto_err stays set until reset, including across start and stop pulses.
- R10: txn_start or txn_stop returns the parser to PS_ADDR and ends streaming. A byte presented in the same cycle is discarded. Row and column keep their values, including the position reached by streaming.
- R11: After reset, wr_en and proto_err are 0, the parser is in PS_ADDR, and row and column are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| txn_start | input | 1 | One-cycle pulse at the start of a write transaction |
| txn_stop | input | 1 | One-cycle pulse at the end of a transaction |
| byte_valid | input | 1 | byte_data holds a received byte this cycle |
| byte_data | input | 8 | Received byte |
| wr_en | output | 1 | Display memory write strobe |
| wr_row | output | ROW_W | Write row |
| wr_col | output | COL_W | Write column |
| wr_data | output | 8 | Write data |
| proto_err | output | 1 | Sticky flag for a dropped out-of-range address byte |

## Verification
The assertions check five properties on every cycle:
- streaming holds until a start or stop pulse;
- a start or stop pulse leads to PS_ADDR with no write;
- every write strobe traces back to an accepted byte one cycle earlier;
- the error flag stays set once raised;
- the position wraps at the last column and writes stay inside the memory.

Other behaviour can only be shown by the bench's byte sequences:
- that the right row and column reach memory under triplet, pair and streaming, including every position of the memory;
- that address-shaped bytes in streaming become data;
- that out-of-range bytes leave the position untouched;
- that the position is retained after a stop.

// File: rtl/osd_cmd_pkg.sv
package osd_cmd_pkg;

    typedef enum logic [1:0] {
        PS_ADDR   = 2'd0,
        PS_DATA   = 2'd1,
        PS_STREAM = 2'd2
    } parse_state_e;

endpackage

// File: rtl/osd_byte_decode.sv
module osd_byte_decode #(
    parameter int NUM_ROWS = 18,
    parameter int NUM_COLS = 30,
    parameter int ROW_W    = 5,
    parameter int COL_W    = 6
) (
    input  logic [7:0]       byte_in,
    output logic             is_row,
    output logic             is_stream,
    output logic [ROW_W-1:0] row_f,
    output logic [COL_W-1:0] col_f,
    output logic             addr_ok
);
    localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(NUM_ROWS - 1);
    localparam logic [COL_W-1:0] COL_LAST = COL_W'(NUM_COLS - 1);

    always_comb begin
        is_row    = byte_in[7];
        is_stream = byte_in[6];
        row_f     = byte_in[ROW_W-1:0];
        col_f     = byte_in[COL_W-1:0];
        addr_ok   = is_row ? (row_f <= ROW_LAST) : (col_f <= COL_LAST);
    end
endmodule

// File: rtl/osd_pos_tracker.sv
module osd_pos_tracker #(
    parameter int NUM_ROWS = 18,
    parameter int NUM_COLS = 30,
    parameter int ROW_W    = 5,
    parameter int COL_W    = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_row,
    input  logic             ld_col,
    input  logic             step,
    input  logic [ROW_W-1:0] row_in,
    input  logic [COL_W-1:0] col_in,
    output logic [ROW_W-1:0] row_q,
    output logic [COL_W-1:0] col_q
);
    localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(NUM_ROWS - 1);
    localparam logic [COL_W-1:0] COL_LAST = COL_W'(NUM_COLS - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_q <= '0;
            col_q <= '0;
        end else if (ld_row) begin
            row_q <= row_in;
        end else if (ld_col) begin
            col_q <= col_in;
        end else if (step) begin
            if (col_q == COL_LAST) begin
                col_q <= '0;
                row_q <= (row_q == ROW_LAST) ? '0 : row_q + ROW_W'(1);
            end else begin
                col_q <= col_q + COL_W'(1);
            end
        end
    end

    // R7: the last column is followed by column 0
    assert_col_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !ld_row && !ld_col && col_q == COL_LAST) |=> (col_q == '0));
endmodule

// File: rtl/osd_wr_port.sv
module osd_wr_port #(
    parameter int NUM_ROWS = 18,
    parameter int NUM_COLS = 30,
    parameter int ROW_W    = 5,
    parameter int COL_W    = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic [ROW_W-1:0] row_in,
    input  logic [COL_W-1:0] col_in,
    input  logic [7:0]       data_in,
    output logic             wr_en,
    output logic [ROW_W-1:0] wr_row,
    output logic [COL_W-1:0] wr_col,
    output logic [7:0]       wr_data
);
    localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(NUM_ROWS - 1);
    localparam logic [COL_W-1:0] COL_LAST = COL_W'(NUM_COLS - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            wr_row  <= '0;
            wr_col  <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= fire;
            if (fire) begin
                wr_row  <= row_in;
                wr_col  <= col_in;
                wr_data <= data_in;
            end
        end
    end

    // R7: writes never leave the memory
    assert_wr_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_row <= ROW_LAST && wr_col <= COL_LAST));
endmodule

// File: rtl/osd_cmd_parser.sv
module osd_cmd_parser
    import osd_cmd_pkg::*;
#(
    parameter int NUM_ROWS = 18,
    parameter int NUM_COLS = 30,
    parameter int ROW_W    = 5,
    parameter int COL_W    = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             txn_start,
    input  logic             txn_stop,
    input  logic             byte_valid,
    input  logic [7:0]       byte_data,
    output logic             wr_en,
    output logic [ROW_W-1:0] wr_row,
    output logic [COL_W-1:0] wr_col,
    output logic [7:0]       wr_data,
    output logic             proto_err
);
    parse_state_e     state_q, state_d;
    logic             is_row, is_stream, addr_ok;
    logic [ROW_W-1:0] row_f, cur_row;
    logic [COL_W-1:0] col_f, cur_col;
    logic             ld_row, ld_col, step, fire, err_set;

    osd_byte_decode #(.NUM_ROWS(NUM_ROWS), .NUM_COLS(NUM_COLS), .ROW_W(ROW_W), .COL_W(COL_W)) u_decode (
        .byte_in(byte_data), .is_row(is_row), .is_stream(is_stream),
        .row_f(row_f), .col_f(col_f), .addr_ok(addr_ok)
    );

    osd_pos_tracker #(.NUM_ROWS(NUM_ROWS), .NUM_COLS(NUM_COLS), .ROW_W(ROW_W), .COL_W(COL_W)) u_pos (
        .clk(clk), .rst_n(rst_n), .ld_row(ld_row), .ld_col(ld_col), .step(step),
        .row_in(row_f), .col_in(col_f), .row_q(cur_row), .col_q(cur_col)
    );

    osd_wr_port #(.NUM_ROWS(NUM_ROWS), .NUM_COLS(NUM_COLS), .ROW_W(ROW_W), .COL_W(COL_W)) u_wr (
        .clk(clk), .rst_n(rst_n), .fire(fire), .row_in(cur_row), .col_in(cur_col),
        .data_in(byte_data), .wr_en(wr_en), .wr_row(wr_row), .wr_col(wr_col), .wr_data(wr_data)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= PS_ADDR;
            proto_err <= 1'b0;
        end else begin
            state_q <= state_d;
            if (err_set) proto_err <= 1'b1;
        end
    end

    // Next state and outputs
    always_comb begin
        state_d = state_q;
        ld_row  = 1'b0;
        ld_col  = 1'b0;
        step    = 1'b0;
        fire    = 1'b0;
        err_set = 1'b0;
        if (txn_start || txn_stop) begin
            state_d = PS_ADDR;
        end else if (byte_valid) begin
            unique case (state_q)
                PS_ADDR: begin
                    if (!addr_ok) begin
                        err_set = 1'b1;
                    end else if (is_row) begin
                        ld_row = 1'b1;
                    end else begin
                        ld_col  = 1'b1;
                        state_d = is_stream ? PS_STREAM : PS_DATA;
                    end
                end
                PS_DATA: begin
                    fire    = 1'b1;
                    state_d = PS_ADDR;
                end
                PS_STREAM: begin
                    fire = 1'b1;
                    step = 1'b1;
                end
                default: state_d = PS_ADDR;
            endcase
        end
    end

    // R6: streaming is left only through a start or stop pulse
    assert_stream_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_STREAM && !txn_start && !txn_stop) |=> (state_q == PS_STREAM));

    // R10: a start or stop pulse leads to PS_ADDR with no write
    assert_ctrl_to_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_start || txn_stop) |=> (state_q == PS_ADDR && !wr_en));

    // R8: every write comes from a byte accepted one cycle earlier
    assert_wr_follows_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(byte_valid && !txn_start && !txn_stop));

    // R1: an address byte produces no write
    assert_addr_no_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && !txn_start && !txn_stop && state_q == PS_ADDR) |=> !wr_en);

    // R9: the error flag is sticky
    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err);
endmodule

// File: tb/osd_cmd_parser_tb.sv
module osd_cmd_parser_tb;
    localparam int NUM_ROWS = 18;
    localparam int NUM_COLS = 30;
    localparam int ROW_W    = 5;
    localparam int COL_W    = 6;
    localparam int CELLS    = NUM_ROWS * NUM_COLS;
    localparam int EW       = ROW_W + COL_W + 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             txn_start = 1'b0;
    logic             txn_stop = 1'b0;
    logic             byte_valid = 1'b0;
    logic [7:0]       byte_data = 8'h00;
    logic             wr_en;
    logic [ROW_W-1:0] wr_row;
    logic [COL_W-1:0] wr_col;
    logic [7:0]       wr_data;
    logic             proto_err;

    int checks = 0;
    int failures = 0;
    logic [EW-1:0] exp_q[$];
    string         tag_q[$];

    always #4 clk = ~clk;

    osd_cmd_parser #(.NUM_ROWS(NUM_ROWS), .NUM_COLS(NUM_COLS), .ROW_W(ROW_W), .COL_W(COL_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .txn_stop(txn_stop),
        .byte_valid(byte_valid), .byte_data(byte_data), .wr_en(wr_en), .wr_row(wr_row),
        .wr_col(wr_col), .wr_data(wr_data), .proto_err(proto_err)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        byte_valid = 1'b1;
        byte_data  = b;
        @(negedge clk);
        byte_valid = 1'b0;
    endtask

    task automatic expect_wr(input int r, input int c, input logic [7:0] d, input string tag);
        exp_q.push_back({ROW_W'(r), COL_W'(c), d});
        tag_q.push_back(tag);
    endtask

    task automatic stream_exp(input int base, input int k, input logic [7:0] d, input string tag);
        int idx;
        idx = (base + k) % CELLS;
        expect_wr(idx / NUM_COLS, idx % NUM_COLS, d, tag);
    endtask

    // Compare every write against the expected queue
    always @(negedge clk) begin
        if (rst_n && wr_en) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R8 unexpected write", int'({wr_row, wr_col, wr_data}), 0);
            end else begin
                logic [EW-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({wr_row, wr_col, wr_data} == e, t, int'({wr_row, wr_col, wr_data}), int'(e));
            end
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(wr_en == 1'b0, "R11 wr_en after reset", int'(wr_en), 0);
        check(proto_err == 1'b0, "R11 proto_err after reset", int'(proto_err), 0);

        // R11 / R2 / R8: row starts at 0; write appears for one cycle
        expect_wr(0, 5, 8'h11, "R11 R2 reset row is 0");
        send(8'h05);
        send(8'h11);
        check(wr_en == 1'b1, "R8 strobe one cycle after data", int'(wr_en), 1);
        @(negedge clk);
        check(wr_en == 1'b0, "R8 strobe single cycle", int'(wr_en), 0);

        // R4: triplets at every position
        for (int r = 0; r < NUM_ROWS; r++) begin
            for (int c = 0; c < NUM_COLS; c++) begin
                logic [7:0] d;
                d = 8'((r * 7 + c) ^ 8'h5A);
                expect_wr(r, c, d, "R4 triplet");
                send(8'h80 | 8'(r));
                send(8'(c));
                send(d);
            end
        end

        // R3 / R2: pairs reuse row 9; data values shaped like addresses
        send(8'h89);
        for (int c = 0; c < NUM_COLS; c++) begin
            logic [7:0] d;
            d = 8'(8'hC0 + c);
            expect_wr(9, c, d, "R3 pair reuses row");
            send(8'(c));
            send(d);
        end

        // R1: row bytes alone write nothing; last one wins
        send(8'h82);
        send(8'h83);
        repeat (2) @(negedge clk);
        expect_wr(3, 1, 8'h21, "R1 last row loaded");
        send(8'h01);
        send(8'h21);

        // R10: start with a byte in the same cycle discards the byte
        send(8'h04);
        txn_start  = 1'b1;
        byte_valid = 1'b1;
        byte_data  = 8'h99;
        @(negedge clk);
        txn_start  = 1'b0;
        byte_valid = 1'b0;
        expect_wr(3, 6, 8'h77, "R10 start discards byte");
        send(8'h06);
        send(8'h77);

        // R9: out-of-range addresses are dropped and flag is sticky
        repeat (2) @(negedge clk);
        check(proto_err == 1'b0, "R9 no error yet", int'(proto_err), 0);
        for (int r = NUM_ROWS; r < 32; r++) send(8'h80 | 8'(r));
        check(proto_err == 1'b1, "R9 bad row sets flag", int'(proto_err), 1);
        for (int c = NUM_COLS; c < 64; c++) send(8'(c));
        send(8'h7F);
        expect_wr(3, 2, 8'h33, "R9 bad bytes change nothing");
        send(8'h02);
        send(8'h33);
        txn_stop = 1'b1;
        @(negedge clk);
        txn_stop = 1'b0;
        @(negedge clk);
        check(proto_err == 1'b1, "R9 flag survives stop", int'(proto_err), 1);

        // R5 / R6 / R7: triplet to streaming from (17,28), exit attempts written
        send(8'h91);
        send(8'h40 | 8'd28);
        begin
            logic [7:0] sd [5];
            sd[0] = 8'h85; sd[1] = 8'h45; sd[2] = 8'hC0; sd[3] = 8'h12; sd[4] = 8'h03;
            for (int k = 0; k < 5; k++) begin
                stream_exp(17 * NUM_COLS + 28, k, sd[k], "R6 R7 stream wrap");
                send(sd[k]);
            end
        end

        // R10: stop ends streaming, position retained (now row 0)
        txn_stop = 1'b1;
        @(negedge clk);
        txn_stop = 1'b0;
        expect_wr(0, 7, 8'hEE, "R10 stop exits stream");
        send(8'h07);
        send(8'hEE);

        // R5 / R7: long back-to-back stream from (3,7) covering every cell
        send(8'h83);
        send(8'h47);
        for (int k = 0; k < CELLS + 5; k++) begin
            stream_exp(3 * NUM_COLS + 7, k, 8'(k), "R5 R7 full stream");
            send(8'(k));
        end
        txn_start = 1'b1;
        @(negedge clk);
        txn_start = 1'b0;
        // position after stream: (97 + 545) mod 540 = 102 -> row 3
        expect_wr((3 * NUM_COLS + 7 + CELLS + 5) % CELLS / NUM_COLS, 0, 8'h5A, "R10 row kept after stream");
        send(8'h00);
        send(8'h5A);

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R8 every data byte written", exp_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule